// File: doc/BRIEF.md
# Touch Digitizer Serial Conversion Interface

This block is the device side of the synchronous serial port of a resistive touch screen digitizer. A host drives a serial clock, an active-low select and a data input. The block hunts for a start bit and collects an 8-bit command. It opens an acquisition window of three serial clocks and then holds the sample. It then shifts a 12-bit or 8-bit result out, most significant bit first. The result comes from a behavioural converter model through a parallel port at the moment the sample is held. The serial clock paces the whole conversion. The decoded command fields go to neighbouring logic, which sets the analog switches and the reference.

All pins are oversampled by a fast system clock with a synchronous active-high reset, and serial clock edges are found as sampled transitions. While select stays low, the block keeps hunting for start bits. A new command can therefore overlap the shifting of the previous result. A hold-off after each command sets the shortest frame: 15 serial clocks in 12-bit mode and 11 in 8-bit mode.

Top module: `touch_serial_if`

## Requirements
- R1: While no command is open and no hold-off is pending, a low data input on a serial clock rising edge is ignored. The first high bit sampled on a rising edge is the start bit and opens an 8-bit command.
- R2: The seven bits after the start bit, sampled on the next seven rising edges, are channel[2:0] (MSB first), then width select, then reference select, then power[1:0]. One system clock after the eighth rising edge, `cw_valid` pulses for one cycle and the field outputs show the new command.
- R3: `dout` is low while command bits are being received, unless an earlier result is still being shifted out.
- R4: `acq_track` rises on the fifth serial clock falling edge after the start bit and falls on the eighth falling edge. At that edge the parallel result is captured.
- R5: `busy` is high from the eighth falling edge until the ninth falling edge.
- R6: With width select 0, the 12 result bits are launched MSB first on falling edges 9 to 20, and `dout` returns low on edge 21. A 24-clock frame thus shows 9 zeros, 12 data bits and 3 zeros.
- R7: With width select 1, the upper 8 bits of the parallel result are launched on falling edges 9 to 16, and `dout` returns low on edge 17.
- R8: After a 12-bit command, high data on the next seven rising edges is ignored, and a start bit is accepted on the eighth rising edge. After an 8-bit command, three rising edges are ignored and a start bit is accepted on the fourth.
- R9: While `cs_n` is high, `dout_oe` and `busy_oe` are low, `busy` and `dout` are low, the data input is ignored, and any conversion in progress is abandoned.
- R10: While `cs_n` is low, `dout_oe` and `busy_oe` are high.
- R11: A command that starts at the end of the hold-off, while the previous result is still being shifted out, leaves that result intact and yields its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| dclk | input | 1 | Serial clock from the host; paces the conversion |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial command data |
| conv_data | input | 12 | Parallel result from the converter model |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| busy | output | 1 | Conversion-held indicator |
| busy_oe | output | 1 | Output enable for `busy` |
| acq_track | output | 1 | High while the input is being acquired |
| cw_valid | output | 1 | One-cycle strobe when a command completes |
| cw_chan | output | 3 | Decoded channel select |
| cw_narrow | output | 1 | Decoded width select (1 = 8-bit) |
| cw_single | output | 1 | Decoded reference select (1 = single-ended) |
| cw_pwr | output | 2 | Decoded power-management field |

## Verification
The assertions check on every cycle the rules that link the receiver and the transmitter. A rising edge during hold-off never opens a command. A capture is always preceded by tracking, and tracking is still high when the command strobe fires. `dout` stays low while a command is open and no result is shifting. A capture never lands on a result still being shifted out. `busy` lasts until a falling edge, and `busy` never shows with its driver disabled. Other behaviours can only be shown by the bench scenarios and its reference model: the exact bit positions of the result in 12-bit and 8-bit frames, the field decode, the rejection of high data during hold-off, overlapped back-to-back commands, and an abort through select followed by a clean restart.

// File: rtl/tdsi_pkg.sv
package tdsi_pkg;

    localparam int RES_W       = 12;  // full conversion width
    localparam int NARROW_W    = 8;   // reduced conversion width
    localparam int CW_BITS     = 8;   // command length including start bit
    localparam int TRACK_EDGE  = 5;   // falling edge that opens acquisition
    localparam int HOLD_WIDE   = 7;   // rising edges ignored after a 12-bit command
    localparam int HOLD_NARROW = 3;   // rising edges ignored after an 8-bit command
    localparam int CNT_W       = $clog2(RES_W + 1);
    localparam int BCNT_W      = $clog2(CW_BITS + 1);
    localparam int HOLD_W      = $clog2(HOLD_WIDE + 1);
    localparam int BODY_W      = CW_BITS - 1;

    typedef struct packed {
        logic [2:0] chan;
        logic       narrow;
        logic       single_ref;
        logic [1:0] pwr;
    } ctrl_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_HELD  = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;

    function automatic ctrl_t unpack_ctrl(input logic [BODY_W-1:0] body);
        ctrl_t c;
        c.chan       = body[6:4];
        c.narrow     = body[3];
        c.single_ref = body[2];
        c.pwr        = body[1:0];
        return c;
    endfunction

    function automatic logic [HOLD_W-1:0] holdoff_for(input logic narrow);
        return narrow ? HOLD_W'(HOLD_NARROW) : HOLD_W'(HOLD_WIDE);
    endfunction

    function automatic logic [CNT_W-1:0] result_len(input logic narrow);
        return narrow ? CNT_W'(NARROW_W) : CNT_W'(RES_W);
    endfunction

endpackage

// File: rtl/tdsi_pins.sv
module tdsi_pins (
    input  logic clk,
    input  logic rst,
    input  logic dclk,
    input  logic cs_n,
    input  logic din,
    output logic rise,
    output logic fall,
    output logic active,
    output logic din_s
);
    logic dclk_q, dclk_qq, cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_q  <= 1'b0;
            dclk_qq <= 1'b0;
            cs_q    <= 1'b1;
            din_s   <= 1'b0;
        end else begin
            dclk_q  <= dclk;
            dclk_qq <= dclk_q;
            cs_q    <= cs_n;
            din_s   <= din;
        end
    end

    assign active = !cs_q;
    assign rise   = dclk_q && !dclk_qq;
    assign fall   = !dclk_q && dclk_qq;

endmodule

// File: rtl/tdsi_cmd_rx.sv
module tdsi_cmd_rx
    import tdsi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  rise,
    input  logic  fall,
    input  logic  din_s,
    output logic  cw_valid,
    output ctrl_t cw,
    output logic  take,
    output logic  take_narrow,
    output logic  track,
    output logic  word_open
);
    logic [BCNT_W-1:0] bcnt;
    logic [BODY_W-2:0] sh;
    logic [HOLD_W-1:0] hold;
    logic              pend;
    logic [BODY_W-1:0] nxt_body;
    ctrl_t             nxt_ctrl;

    always_comb begin
        nxt_body = {sh, din_s};
        nxt_ctrl = unpack_ctrl(nxt_body);
    end

    always_ff @(posedge clk) begin
        cw_valid <= 1'b0;
        take     <= 1'b0;
        if (rst) begin
            cw          <= '0;
            take_narrow <= 1'b0;
        end
        if (rst || !active) begin
            word_open <= 1'b0;
            bcnt      <= '0;
            sh        <= '0;
            hold      <= '0;
            pend      <= 1'b0;
            track     <= 1'b0;
        end else begin
            if (rise) begin
                if (word_open) begin
                    sh   <= nxt_body[BODY_W-2:0];
                    bcnt <= bcnt + BCNT_W'(1);
                    if (bcnt == BCNT_W'(CW_BITS - 1)) begin
                        word_open <= 1'b0;
                        cw        <= nxt_ctrl;
                        cw_valid  <= 1'b1;
                        hold      <= holdoff_for(nxt_ctrl.narrow);
                        pend      <= 1'b1;
                    end
                end else if (hold != '0) begin
                    hold <= hold - HOLD_W'(1);
                end else if (din_s) begin
                    word_open <= 1'b1;
                    bcnt      <= BCNT_W'(1);
                    sh        <= '0;
                end
            end
            if (fall) begin
                if (word_open && bcnt == BCNT_W'(TRACK_EDGE))
                    track <= 1'b1;
                if (pend) begin
                    pend        <= 1'b0;
                    track       <= 1'b0;
                    take        <= 1'b1;
                    take_narrow <= cw.narrow;
                end
            end
        end
    end

    // R8: a rising edge inside the hold-off never opens a command
    a_r8_holdoff_blocks: assert property (@(posedge clk) disable iff (rst)
        (rise && !word_open && hold != '0) |=> !word_open);

    // R4: capture only after the acquisition window was open
    a_r4_take_after_track: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(track));

    // R4: tracking is already open when the command completes
    a_r4_track_at_word_end: assert property (@(posedge clk) disable iff (rst)
        cw_valid |-> track);

endmodule

// File: rtl/tdsi_result_tx.sv
module tdsi_result_tx
    import tdsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             fall,
    input  logic             take,
    input  logic             take_narrow,
    input  logic [RES_W-1:0] conv_data,
    output logic             dout,
    output logic             busy,
    output logic             shifting
);
    tx_state_e        st;
    logic [RES_W-1:0] sh;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            st   <= TX_IDLE;
            sh   <= '0;
            cnt  <= '0;
            dout <= 1'b0;
        end else if (take) begin
            st  <= TX_HELD;
            sh  <= conv_data;
            cnt <= result_len(take_narrow);
        end else if (fall) begin
            case (st)
                TX_HELD: begin
                    st   <= TX_SHIFT;
                    dout <= sh[RES_W-1];
                    sh   <= {sh[RES_W-2:0], 1'b0};
                    cnt  <= cnt - CNT_W'(1);
                end
                TX_SHIFT: begin
                    if (cnt != '0) begin
                        dout <= sh[RES_W-1];
                        sh   <= {sh[RES_W-2:0], 1'b0};
                        cnt  <= cnt - CNT_W'(1);
                    end else begin
                        dout <= 1'b0;
                        st   <= TX_IDLE;
                    end
                end
                default: dout <= 1'b0;
            endcase
        end
    end

    assign busy     = (st == TX_HELD);
    assign shifting = (st == TX_SHIFT);

    // R5: busy persists until a serial falling edge
    a_r5_busy_until_fall: assert property (@(posedge clk) disable iff (rst || !active)
        (st == TX_HELD && !fall && !take) |=> st == TX_HELD);

    // R6: the bit counter never exceeds the full width
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(RES_W));

endmodule

// File: rtl/touch_serial_if.sv
module touch_serial_if
    import tdsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dclk,
    input  logic             cs_n,
    input  logic             din,
    input  logic [RES_W-1:0] conv_data,
    output logic             dout,
    output logic             dout_oe,
    output logic             busy,
    output logic             busy_oe,
    output logic             acq_track,
    output logic             cw_valid,
    output logic [2:0]       cw_chan,
    output logic             cw_narrow,
    output logic             cw_single,
    output logic [1:0]       cw_pwr
);
    logic  rise, fall, active, din_s;
    logic  take, take_narrow, word_open, shifting;
    logic  oe_q;
    ctrl_t cw;

    tdsi_pins u_pins (
        .clk    (clk),
        .rst    (rst),
        .dclk   (dclk),
        .cs_n   (cs_n),
        .din    (din),
        .rise   (rise),
        .fall   (fall),
        .active (active),
        .din_s  (din_s)
    );

    tdsi_cmd_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .rise        (rise),
        .fall        (fall),
        .din_s       (din_s),
        .cw_valid    (cw_valid),
        .cw          (cw),
        .take        (take),
        .take_narrow (take_narrow),
        .track       (acq_track),
        .word_open   (word_open)
    );

    tdsi_result_tx u_tx (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .fall        (fall),
        .take        (take),
        .take_narrow (take_narrow),
        .conv_data   (conv_data),
        .dout        (dout),
        .busy        (busy),
        .shifting    (shifting)
    );

    always_ff @(posedge clk) begin
        if (rst) oe_q <= 1'b0;
        else     oe_q <= active;
    end

    assign dout_oe   = oe_q;
    assign busy_oe   = oe_q;
    assign cw_chan   = cw.chan;
    assign cw_narrow = cw.narrow;
    assign cw_single = cw.single_ref;
    assign cw_pwr    = cw.pwr;

    // R3: data line is quiet while a command is open and nothing shifts
    a_r3_quiet_during_cmd: assert property (@(posedge clk) disable iff (rst)
        (word_open && !shifting) |-> !dout);

    // R11: a new capture never lands on a result still being shifted
    a_r11_no_clobber: assert property (@(posedge clk) disable iff (rst)
        take |-> !shifting);

    // R10: busy is never shown with its driver disabled
    a_r10_busy_driven: assert property (@(posedge clk) disable iff (rst)
        busy |-> busy_oe);

endmodule

// File: tb/sim_touch_serial_if.sv
module sim_touch_serial_if;

    logic        clk = 1'b0, rst = 1'b1, dclk = 1'b0, cs_n = 1'b1, din = 1'b0;
    logic [11:0] conv = 12'h000;
    logic        dout, dout_oe, busy, busy_oe, acq_track, cw_valid;
    logic [2:0]  cw_chan;
    logic        cw_narrow, cw_single;
    logic [1:0]  cw_pwr;

    always #5 clk = ~clk;

    touch_serial_if u0 (
        .clk(clk), .rst(rst), .dclk(dclk), .cs_n(cs_n), .din(din),
        .conv_data(conv), .dout(dout), .dout_oe(dout_oe), .busy(busy),
        .busy_oe(busy_oe), .acq_track(acq_track), .cw_valid(cw_valid),
        .cw_chan(cw_chan), .cw_narrow(cw_narrow), .cw_single(cw_single),
        .cw_pwr(cw_pwr)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // behavioural reference
    int    m_wpos = -1, m_word = 0, m_hold = 0, m_words = 0, m_last = 0;
    bit    m_pend = 0, m_track = 0, m_busy = 0, m_dout = 0, m_done = 0;
    bit    m_q[$];
    string m_dtag = "R3";

    int         got_words = 0;
    logic [6:0] got_fields = '0;
    always @(posedge clk) if (cw_valid) begin
        got_words  <= got_words + 1;
        got_fields <= {cw_chan, cw_narrow, cw_single, cw_pwr};
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cs_n ? "R9" : "R10", "dout_oe", int'(dout_oe), int'(!cs_n));
        chk(cs_n ? "R9" : "R10", "busy_oe", int'(busy_oe), int'(!cs_n));
        chk(cs_n ? "R9" : "R5", "busy", int'(busy), int'(m_busy));
        chk(cs_n ? "R9" : m_dtag, "dout", int'(dout), int'(m_dout));
        chk("R4", "acq_track", int'(acq_track), int'(m_track));
        if (m_done) begin
            chk("R2", "fields", int'(got_fields), m_last);
            chk("R2", "strobe count", got_words, m_words);
            m_done = 0;
        end
    endtask

    task automatic half();
        repeat (6) @(negedge clk);
        compare_all();
    endtask

    task automatic model_reset();
        m_wpos = -1; m_hold = 0; m_pend = 0; m_track = 0;
        m_busy = 0; m_dout = 0; m_q.delete(); m_dtag = "R3";
    endtask

    task automatic model_rise(bit b);
        if (cs_n) return;
        if (m_wpos >= 0) begin
            m_word = m_word * 2 + int'(b);
            m_wpos++;
            if (m_wpos == 8) begin
                m_wpos  = -1;
                m_last  = m_word & 127;
                m_words++;
                m_done  = 1;
                m_hold  = ((m_word >> 3) & 1) != 0 ? 3 : 7;
                m_pend  = 1;
            end
        end else if (m_hold > 0) begin
            m_hold--;
        end else if (b) begin
            m_wpos = 1;
            m_word = 1;
        end
    endtask

    task automatic model_fall();
        bit nar;
        if (cs_n) return;
        if (m_wpos == 5) m_track = 1;
        m_busy = 0;
        if (m_q.size() > 0) m_dout = m_q.pop_front();
        else                m_dout = 0;
        if (m_pend) begin
            m_pend  = 0;
            m_track = 0;
            m_busy  = 1;
            nar     = ((m_last >> 3) & 1) != 0;
            for (int i = 0; i < (nar ? 8 : 12); i++) m_q.push_back(conv[11-i]);
            m_dtag = nar ? "R7" : "R6";
        end
    endtask

    task automatic cycle(bit b);
        din = b;
        half();
        dclk = 1'b1;
        model_rise(b);
        half();
        dclk = 1'b0;
        model_fall();
    endtask

    task automatic send_bits(int val, int n);
        for (int i = n - 1; i >= 0; i--) cycle(val[i]);
    endtask

    task automatic set_cs(bit v);
        cs_n = v;
        if (v) model_reset();
        half();
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        half();
        chk("R9", "reset dout_oe", int'(dout_oe), 0);
        chk("R9", "reset busy", int'(busy), 0);

        // R1: leading zeros are ignored, then a 24-clock 12-bit frame (R6)
        set_cs(1'b0);
        conv = 12'hA5C;
        send_bits(0, 3);
        chk("R1", "no word from zeros", got_words, 0);
        send_bits(8'b1_001_0_1_00, 8);
        send_bits(0, 16);

        // R7: 8-bit frame uses the upper bits
        conv = 12'h3F1;
        send_bits(8'b1_101_1_0_11, 8);
        send_bits(0, 12);

        // R8 and R11: 15-clock overlapped 12-bit frames, high data in hold-off
        base = got_words;
        conv = 12'h5A3;
        send_bits(8'b1_011_0_1_10, 8);
        send_bits(7'h7F, 7);
        conv = 12'h9E7;
        send_bits(8'b1_010_0_0_01, 8);
        send_bits(0, 20);
        chk("R8", "12-bit hold-off word count", got_words, base + 2);

        // R8 and R11: 11-clock overlapped 8-bit frames
        base = got_words;
        conv = 12'hC3F;
        send_bits(8'b1_000_1_1_00, 8);
        send_bits(3'b111, 3);
        conv = 12'h0FF;
        send_bits(8'b1_110_1_1_01, 8);
        send_bits(0, 16);
        chk("R8", "8-bit hold-off word count", got_words, base + 2);

        // R9: abort mid-result, ignore data while deselected, then restart
        conv = 12'hFFF;
        send_bits(8'b1_001_0_1_11, 8);
        send_bits(0, 4);
        set_cs(1'b1);
        chk("R9", "abort busy", int'(busy), 0);
        chk("R9", "abort dout", int'(dout), 0);
        base = got_words;
        send_bits(8'hFF, 8);
        chk("R9", "deselected data ignored", got_words, base);
        set_cs(1'b0);
        conv = 12'h801;
        send_bits(8'b1_111_0_1_00, 8);
        send_bits(0, 16);
        conv = 12'h000;
        send_bits(8'b1_100_1_0_10, 8);
        send_bits(0, 12);
        set_cs(1'b1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule